// File: doc/BRIEF.md
# Subtract-and-Branch-if-Negative Processor

This block is a small multicycle processor with exactly one instruction. Each instruction takes three consecutive memory words. The first word is the address of the subtrahend. The second word is the address of the minuend, and the difference is written back to that same location. The third word is a branch target. The processor computes minuend minus subtrahend and stores the result. If the result is negative, it jumps to the target; otherwise it moves on to the next three-word instruction.

Control and datapath are separate modules. The controller steps through one memory access per state and drives the datapath through a packed struct of strobes. The subtraction is done in a plain adder: the subtrahend register is inverted and a carry-in of one is added. Two registered flags record the result: a negative flag (sign bit) and a zero flag. The negative flag selects the next program counter.

The processor runs against a single-port synchronous memory. Read data appears one cycle after the address. An instruction that jumps to its own address stops the machine.

Top module: `sbn_core`

## Requirements
- R1: While reset is low and in the first cycle after it, `halted` is 0, and the processor issues a read (`memRe`=1, `memWe`=0) at word address 0.
- R2: Each instruction reads the words at PC, PC+1 and PC+2, one read per cycle, in that order. It then reads the subtrahend location, then the destination location, and finally writes the destination.
- R3: The word written to the destination is (destination − subtrahend) modulo 2^32. The write occurs at the address held in the second instruction word.
- R4: When the result has bit 31 set (negative), the next PC is the value of the third instruction word.
- R5: When the result has bit 31 clear, the next PC is PC+3, wrapping modulo the address space.
- R6: If both address words point to the same location, that location becomes 0 and no branch is taken.
- R7: Subtracting a location holding 1 from a location holding 0 stores 0xFFFFFFFF and always takes the branch.
- R8: An instruction whose result is negative and whose target equals its own address finishes its write and then raises `halted`. From then on, `halted` stays 1 and no read or write is issued until reset.
- R9: No cycle has both `memRe` and `memWe` high. Each instruction takes exactly 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | AW | Word address of the current memory access |
| memRe | output | 1 | Read request; data is returned on memRdata one cycle later |
| memWe | output | 1 | Write request for memWdata at memAddr |
| memWdata | output | DW | Write data (subtraction result) |
| memRdata | input | DW | Read data from the memory |
| halted | output | 1 | High once a negative jump-to-self has completed |

## Verification
In the write cycle, the destination word arrives from memory and the subtraction result leaves for memory in the same clock. The flags are latched in that clock too. The test provokes this with operand pairs that span zero, the sign boundary and wraparound. It then judges the cycle by reading back the stored word, and by which of two halt stubs was reached (fall-through or branch). Halting is a second coincidence: the branch decision and the self-target comparison resolve in the same PC update. The test checks this with a one-instruction self loop, measuring cycles until `halted` rises and confirming that no accesses follow.

// File: rtl/sbn_pkg.sv
package sbn_pkg;

  typedef enum logic [2:0] {
    SEL_PC0, SEL_PC1, SEL_PC2, SEL_SRC, SEL_DST
  } addrSel_e;

  typedef enum logic [2:0] {
    ST_FA, ST_FB, ST_FC, ST_RSRC, ST_RDST, ST_WR, ST_UPD, ST_HALT
  } state_e;

  typedef struct packed {
    addrSel_e addrSel;
    logic     memRe;
    logic     memWe;
    logic     ldSrc;
    logic     ldDst;
    logic     ldTgt;
    logic     ldOpnd;
    logic     ldFlags;
    logic     ldPc;
    logic     compEn;
    logic     carryIn;
  } strobes_t;

endpackage

// File: rtl/sbn_datapath.sv
module sbn_datapath
  import sbn_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      stb,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          flagN,
  output logic          flagZ,
  output logic          selfTarget
);

  localparam logic [AW-1:0] INSTR_WORDS = AW'(3);

  logic [AW-1:0] pc, srcAddr, dstAddr, tgt;
  logic [DW-1:0] opnd;
  logic [DW-1:0] addB;
  logic [DW-1:0] sum;

  // address path multiplexer
  always_comb begin
    case (stb.addrSel)
      SEL_PC0: memAddr = pc;
      SEL_PC1: memAddr = pc + AW'(1);
      SEL_PC2: memAddr = pc + AW'(2);
      SEL_SRC: memAddr = srcAddr;
      default: memAddr = dstAddr;
    endcase
  end

  // adder with complement and carry-in control
  assign addB     = stb.compEn ? ~opnd : opnd;
  assign sum      = memRdata + addB + DW'(stb.carryIn);
  assign memWdata = sum;
  assign selfTarget = (tgt == pc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      srcAddr <= '0;
      dstAddr <= '0;
      tgt     <= '0;
      opnd    <= '0;
      flagN   <= 1'b0;
      flagZ   <= 1'b0;
    end else begin
      if (stb.ldSrc)  srcAddr <= memRdata[AW-1:0];
      if (stb.ldDst)  dstAddr <= memRdata[AW-1:0];
      if (stb.ldTgt)  tgt     <= memRdata[AW-1:0];
      if (stb.ldOpnd) opnd    <= memRdata;
      if (stb.ldFlags) begin
        flagN <= sum[DW-1];
        flagZ <= (sum == '0);
      end
      if (stb.ldPc) pc <= flagN ? tgt : pc + INSTR_WORDS;
    end
  end

  // R5
  pc_fallthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldPc && !flagN) |=> (pc == $past(pc) + INSTR_WORDS));

  // R4
  pc_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldPc && flagN) |=> (pc == $past(tgt)));

  // R6
  zero_not_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagZ |-> !flagN);

endmodule

// File: rtl/sbn_ctrl.sv
module sbn_ctrl
  import sbn_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     flagN,
  input  logic     selfTarget,
  output strobes_t stb,
  output logic     halted
);

  state_e state, nextState;

  always_comb begin
    stb       = '0;
    stb.addrSel = SEL_PC0;
    nextState = state;
    case (state)
      ST_FA:   begin stb.addrSel = SEL_PC0; stb.memRe = 1'b1; nextState = ST_FB; end
      ST_FB:   begin stb.addrSel = SEL_PC1; stb.memRe = 1'b1; stb.ldSrc = 1'b1; nextState = ST_FC; end
      ST_FC:   begin stb.addrSel = SEL_PC2; stb.memRe = 1'b1; stb.ldDst = 1'b1; nextState = ST_RSRC; end
      ST_RSRC: begin stb.addrSel = SEL_SRC; stb.memRe = 1'b1; stb.ldTgt = 1'b1; nextState = ST_RDST; end
      ST_RDST: begin stb.addrSel = SEL_DST; stb.memRe = 1'b1; stb.ldOpnd = 1'b1; nextState = ST_WR; end
      ST_WR: begin
        stb.addrSel = SEL_DST;
        stb.memWe   = 1'b1;
        stb.compEn  = 1'b1;
        stb.carryIn = 1'b1;
        stb.ldFlags = 1'b1;
        nextState   = ST_UPD;
      end
      ST_UPD: begin
        stb.ldPc  = 1'b1;
        nextState = (flagN && selfTarget) ? ST_HALT : ST_FA;
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FA;
    else       state <= nextState;
  end

  assign halted = (state == ST_HALT);

  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.memRe && stb.memWe));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!stb.memRe && !stb.memWe));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R2
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWe |-> ($past(stb.memRe) && $past(stb.addrSel) == SEL_DST));

endmodule

// File: rtl/sbn_core.sv
module sbn_core
  import sbn_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic          halted
);

  strobes_t stb;
  logic     flagN, flagZ, selfTarget;

  sbn_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flagN      (flagN),
    .selfTarget (selfTarget),
    .stb        (stb),
    .halted     (halted)
  );

  sbn_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .flagN      (flagN),
    .flagZ      (flagZ),
    .selfTarget (selfTarget)
  );

  assign memRe = stb.memRe;
  assign memWe = stb.memWe;

endmodule

// File: tb/tb_sbn_core.sv
module tb_sbn_core;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NVEC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] memAddr;
  logic          memRe, memWe;
  logic [DW-1:0] memWdata, memRdata;
  logic          halted;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  int nChecks = 0;
  int nFails  = 0;
  int overlap = 0;

  always #2 clk = ~clk;

  sbn_core #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  always @(negedge clk) if (rstN && memRe && memWe) overlap++;

  // {subtrahend, minuend, expected difference, expected branch}
  localparam logic [3*DW:0] VEC [NVEC] = '{
    {32'd3,          32'd10,         32'd7,          1'b0},
    {32'd10,         32'd3,          32'hFFFFFFF9,   1'b1},
    {32'd5,          32'd5,          32'd0,          1'b0},
    {32'd1,          32'd0,          32'hFFFFFFFF,   1'b1},
    {32'h80000000,   32'd0,          32'h80000000,   1'b1},
    {32'd1,          32'h80000000,   32'h7FFFFFFF,   1'b0},
    {32'hFFFFFFFF,   32'd0,          32'd1,          1'b0},
    {32'd0,          32'd0,          32'd0,          1'b0}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
  endtask

  // halt stub at addr: 0 - 1 at scratch dst, jump to itself
  task automatic haltStub(input int at, input int dst);
    mem[at] = 32'd103; mem[at+1] = dst; mem[at+2] = at;
  endtask

  task automatic runToHalt(output int cyc);
    cyc = 0;
    @(negedge clk) rstN = 1'b1;
    while (!halted && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=halted");
    end
  endtask

  int cyc;

  initial begin
    // R1: reset state
    clearMem();
    repeat (3) @(negedge clk);
    check("R1 halted in reset", {31'd0, halted}, 32'd0);
    check("R1 read at 0 in reset", {23'd0, memRe, memAddr}, {23'd0, 1'b1, 8'd0});

    // table-driven runs: R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      rstN = 1'b0;
      @(negedge clk);
      clearMem();
      mem[0] = 32'd100; mem[1] = 32'd101; mem[2] = 32'd50;
      mem[100] = VEC[v][3*DW:2*DW+1];
      mem[101] = VEC[v][2*DW:DW+1];
      mem[103] = 32'd1;
      haltStub(3, 104);
      haltStub(50, 105);
      @(negedge clk);
      runToHalt(cyc);
      check("R3 stored difference", mem[101], VEC[v][DW:1]);
      check(VEC[v][0] ? "R4 branch reached" : "R5 fallthrough reached",
            VEC[v][0] ? mem[105] : mem[104], 32'hFFFFFFFF);
      check("R4/R5 other path untouched", VEC[v][0] ? mem[104] : mem[105], 32'd0);
      check("R9 instruction count cycles", cyc, 32'd14);
    end

    // R6: same location as both operands
    rstN = 1'b0;
    @(negedge clk);
    clearMem();
    mem[0] = 32'd101; mem[1] = 32'd101; mem[2] = 32'd50;
    mem[101] = 32'h1234ABCD; mem[103] = 32'd1;
    haltStub(3, 104); haltStub(50, 105);
    @(negedge clk);
    runToHalt(cyc);
    check("R6 self clear", mem[101], 32'd0);
    check("R6 no branch", mem[104], 32'hFFFFFFFF);
    check("R6 branch path untouched", mem[105], 32'd0);

    // R7 and R8: single self loop, R2 access order
    rstN = 1'b0;
    @(negedge clk);
    clearMem();
    mem[103] = 32'd1;
    haltStub(0, 104);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 first access addr 0", {23'd0, memRe, memAddr}, {23'd0, 1'b1, 8'd0});
    @(negedge clk); check("R2 fetch PC+1", {24'd0, memAddr}, 32'd1);
    @(negedge clk); check("R2 fetch PC+2", {24'd0, memAddr}, 32'd2);
    @(negedge clk); check("R2 read subtrahend", {24'd0, memAddr}, 32'd103);
    @(negedge clk); check("R2 read destination", {23'd0, memRe, memAddr}, {23'd0, 1'b1, 8'd104});
    @(negedge clk); check("R2 write destination", {23'd0, memWe, memAddr}, {23'd0, 1'b1, 8'd104});
    check("R7 minus one written", memWdata, 32'hFFFFFFFF);
    @(negedge clk); check("R8 not yet halted", {31'd0, halted}, 32'd0);
    @(negedge clk); check("R8 halted after 7 cycles", {31'd0, halted}, 32'd1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 quiet after halt", {30'd0, memRe, memWe}, 32'd0);
    end
    check("R8 halt stays", {31'd0, halted}, 32'd1);
    check("R7 stored minus one", mem[104], 32'hFFFFFFFF);
    check("R9 no read/write overlap", overlap, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #150000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule